// File: doc/BRIEF.md
# Peripheral Host Bus Slave with DMA Handshake

This block is the host-facing edge of a small peripheral on an 8-bit, ISA-style I/O bus. It watches asynchronous active-low read and write strobes, brings them into the system clock domain, and takes a copy of the 11-bit address when a strobe begins. A programmed I/O access only reaches the block when chip select is low, address enable is low and all address bits fall inside the block's window. A small register file stands in for the peripheral. Entry 0 is a configuration byte that keeps its value through reset, and the other entries are scratch bytes that reset to zero.

The block also runs one DMA channel. It raises an active-high request while the peripheral's data status input reports data ready. It watches an active-low acknowledge and a terminal count input. During acknowledged cycles, with address enable high, it moves bytes through a dedicated register. The interrupt output either follows the peripheral's request as a level, or gives a short low pulse and then releases the line so that several devices can share it. The data bus and the interrupt line are modelled as separate value and enable ports.

Top module: `hostBusSlave`

## Requirements
- R1: After reset, dmaReq and dataOe are 0 and scratch registers read 0. The configuration register (index 0) keeps the value written before reset.
- R2: A programmed access matches only when addr[10:IDX_W] equals BASE_ADDR[10:IDX_W]. The register index is addr[IDX_W-1:0]. An address that differs in any upper bit gives no data drive and no write.
- R3: With csN high, or aen high without an acknowledged DMA cycle, a read does not drive the bus and a write leaves every register unchanged.
- R4: The address is captured when the synchronised strobe falls. Changing addr later in the same strobe does not change the register that is accessed.
- R5: dataOe is 1 only while a captured read is in progress and is either qualified or a DMA read with dmaAckN low. dataOut then carries the addressed register.
- R6: A qualified write stores dataIn into the captured register when the write strobe rises.
- R7: dmaReq rises only while config bit 0 (DMA enable) is 1, fifoReady is 1, acknowledge is high and no terminal count is pending. Clearing bit 0 drops dmaReq.
- R8: With config bit 1 (demand mode) at 0, dmaReq clears when acknowledge falls.
- R9: With demand mode at 1, a falling acknowledge leaves dmaReq high. dmaReq clears when the read strobe falls with acknowledge low and lastByte at 1, and stays high if lastByte is 0.
- R10: termCount is accepted only while acknowledge is low. It clears dmaReq and blocks new requests until the configuration register is written. With acknowledge high it has no effect.
- R11: With config bit 2 (interrupt enable) and bit 3 (shared mode) both at 1, a rising intReq drives irqOut low with irqOe 1 for PULSE_CYCLES cycles. After that irqOe returns to 0.
- R12: With bit 3 at 0, irqOe is 1 and irqOut equals intReq AND bit 2.
- R13: During an acknowledged cycle with aen high, a read returns register DMA_REG and a write stores into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; the configuration register is kept |
| csN | input | 1 | Active-low chip select |
| aen | input | 1 | Address enable; high marks a DMA bus cycle |
| addr | input | ADDR_W | I/O address |
| iorN | input | 1 | Active-low read strobe, asynchronous |
| iowN | input | 1 | Active-low write strobe, asynchronous |
| dataIn | input | 8 | Write data from the host |
| dataOut | output | 8 | Read data toward the host |
| dataOe | output | 1 | Bus drive enable |
| dmaAckN | input | 1 | Active-low DMA acknowledge, asynchronous |
| termCount | input | 1 | Active-high terminal count |
| fifoReady | input | 1 | Peripheral has data ready for transfer |
| lastByte | input | 1 | Next demand-mode read is the final byte |
| dmaReq | output | 1 | Active-high DMA request |
| intReq | input | 1 | Interrupt request from the peripheral |
| irqOut | output | 1 | Interrupt line value |
| irqOe | output | 1 | Interrupt line drive enable |

## Verification
The bench sets BASE_ADDR to 11'h2E8 instead of the default, so the decode is tested with a window whose upper bits differ from the default. It also sets PULSE_CYCLES to 3, so the start and end of the shared interrupt pulse fall inside a short, exact check window. Random accesses flip one upper address bit at a time or drop the chip select or address enable qualifiers. Directed sequences walk the DMA request through single mode, demand mode and the terminal count block.

// File: rtl/hostBusPkg.sv
package hostBusPkg;

  typedef struct packed {
    logic capture;
    logic wrCommit;
    logic rdBusy;
    logic ackLow;
    logic ackFall;
  } hostStrb_t;

  typedef struct packed {
    logic irqShare;
    logic irqEn;
    logic demand;
    logic dmaEn;
  } hostCfg_t;

endpackage

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      iorN,
  input  logic      iowN,
  input  logic      dmaAckN,
  input  logic      termCount,
  input  logic      fifoReady,
  input  logic      lastByte,
  input  logic      intReq,
  input  hostCfg_t  cfg,
  input  logic      cfgWrite,
  output hostStrb_t strb,
  output logic      dmaReq,
  output logic      irqOut,
  output logic      irqOe
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [2:0] syncStage [SYNC_STAGES];
  logic [2:0] syncPrev;
  logic [2:0] syncNow;

  always_ff @(posedge clk) begin
    if (rst) syncStage[0] <= 3'b111;
    else     syncStage[0] <= {iorN, iowN, dmaAckN};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (rst) syncStage[g] <= 3'b111;
      else     syncStage[g] <= syncStage[g-1];
    end
  end

  assign syncNow = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) syncPrev <= 3'b111;
    else     syncPrev <= syncNow;
  end

  logic iorFall, iorRise, iowFall, iowRise, ackFall, ackLow;
  assign iorFall = syncPrev[2] & ~syncNow[2];
  assign iorRise = ~syncPrev[2] & syncNow[2];
  assign iowFall = syncPrev[1] & ~syncNow[1];
  assign iowRise = ~syncPrev[1] & syncNow[1];
  assign ackFall = syncPrev[0] & ~syncNow[0];
  assign ackLow  = ~syncNow[0];

  logic rdBusy;
  always_ff @(posedge clk) begin
    if (rst)          rdBusy <= 1'b0;
    else if (iorFall) rdBusy <= 1'b1;
    else if (iorRise) rdBusy <= 1'b0;
  end

  assign strb.capture  = iorFall | iowFall;
  assign strb.wrCommit = iowRise;
  assign strb.rdBusy   = rdBusy;
  assign strb.ackLow   = ackLow;
  assign strb.ackFall  = ackFall;

  // DMA request with terminal-count lockout
  logic tcDone;
  always_ff @(posedge clk) begin
    if (rst) begin
      dmaReq <= 1'b0;
      tcDone <= 1'b0;
    end else begin
      if (cfgWrite) tcDone <= 1'b0;
      if (termCount && ackLow) begin
        tcDone <= 1'b1;
        dmaReq <= 1'b0;
      end else if (!cfg.dmaEn) begin
        dmaReq <= 1'b0;
      end else if (dmaReq) begin
        if (!cfg.demand && ackFall)                       dmaReq <= 1'b0;
        else if (cfg.demand && ackLow && iorFall && lastByte) dmaReq <= 1'b0;
      end else if (fifoReady && !ackLow && !tcDone) begin
        dmaReq <= 1'b1;
      end
    end
  end

  // Interrupt: level or pulse-and-release
  logic             intPrev;
  logic [CNT_W-1:0] pulseCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      intPrev  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      intPrev <= intReq;
      if (intReq && !intPrev && cfg.irqEn && cfg.irqShare)
        pulseCnt <= CNT_W'(PULSE_CYCLES);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign irqOe  = cfg.irqShare ? (pulseCnt != '0) : 1'b1;
  assign irqOut = cfg.irqShare ? 1'b0 : (intReq & cfg.irqEn);

endmodule

// File: rtl/hostBusDatapath.sv
module hostBusDatapath
  import hostBusPkg::*;
#(
  parameter int              ADDR_W    = 11,
  parameter int              REG_COUNT = 4,
  parameter int              DMA_REG   = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h3F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              aen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  hostStrb_t         strb,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output hostCfg_t          cfg,
  output logic              cfgWrite
);

  localparam int IDX_W = $clog2(REG_COUNT);

  logic [IDX_W-1:0] idxQ;
  logic             hitQ;
  logic             dmaQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0;
      hitQ <= 1'b0;
      dmaQ <= 1'b0;
    end else if (strb.capture) begin
      idxQ <= addr[IDX_W-1:0];
      hitQ <= !csN && !aen && (addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
      dmaQ <= aen && strb.ackLow;
    end
  end

  logic [7:0] regFile [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    logic hostWr, dmaWr;
    assign hostWr = strb.wrCommit && hitQ && (idxQ == IDX_W'(g));
    assign dmaWr  = (g == DMA_REG) && strb.wrCommit && dmaQ && strb.ackLow;
    if (g == 0) begin : gCfg
      // configuration byte survives reset
      logic [7:0] cfgByte = 8'h00;
      always_ff @(posedge clk) begin
        if (hostWr) cfgByte <= dataIn;
      end
      assign regFile[g] = cfgByte;
    end else begin : gScratch
      logic [7:0] scratch;
      always_ff @(posedge clk) begin
        if (rst)                 scratch <= 8'h00;
        else if (hostWr || dmaWr) scratch <= dataIn;
      end
      assign regFile[g] = scratch;
    end
  end

  assign cfgWrite = strb.wrCommit && hitQ && (idxQ == '0);
  assign cfg      = hostCfg_t'(regFile[0][3:0]);
  assign dataOut  = dmaQ ? regFile[DMA_REG] : regFile[idxQ];
  assign dataOe   = strb.rdBusy && (hitQ || (dmaQ && strb.ackLow));

endmodule

// File: rtl/hostBusSlave.sv
module hostBusSlave
  import hostBusPkg::*;
#(
  parameter int                ADDR_W       = 11,
  parameter int                REG_COUNT    = 4,
  parameter int                DMA_REG      = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 11'h3F0,
  parameter int                SYNC_STAGES  = 2,
  parameter int                PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              aen,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  input  logic              dmaAckN,
  input  logic              termCount,
  input  logic              fifoReady,
  input  logic              lastByte,
  output logic              dmaReq,
  input  logic              intReq,
  output logic              irqOut,
  output logic              irqOe
);

  hostStrb_t strb;
  hostCfg_t  cfg;
  logic      cfgWrite;

  hostBusCtrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) uCtrl (
    .clk(clk), .rst(rst), .iorN(iorN), .iowN(iowN), .dmaAckN(dmaAckN),
    .termCount(termCount), .fifoReady(fifoReady), .lastByte(lastByte),
    .intReq(intReq), .cfg(cfg), .cfgWrite(cfgWrite), .strb(strb),
    .dmaReq(dmaReq), .irqOut(irqOut), .irqOe(irqOe)
  );

  hostBusDatapath #(
    .ADDR_W   (ADDR_W),
    .REG_COUNT(REG_COUNT),
    .DMA_REG  (DMA_REG),
    .BASE_ADDR(BASE_ADDR)
  ) uData (
    .clk(clk), .rst(rst), .csN(csN), .aen(aen), .addr(addr), .dataIn(dataIn),
    .strb(strb), .dataOut(dataOut), .dataOe(dataOe), .cfg(cfg), .cfgWrite(cfgWrite)
  );

endmodule

// File: rtl/hostBusChecker.sv
module hostBusChecker
  import hostBusPkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      dataOe,
  input logic      dmaReq,
  input logic      termCount,
  input logic      fifoReady,
  input logic      irqOe,
  input logic      irqOut,
  input hostStrb_t strb,
  input hostCfg_t  cfg
);

  // R5
  data_drive_chk: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> strb.rdBusy);

  // R7
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dmaReq) |-> ($past(fifoReady) && $past(cfg.dmaEn) && !$past(strb.ackLow)));

  // R8
  single_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dmaReq && !cfg.demand && strb.ackFall) |=> !dmaReq);

  // R10
  tc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (termCount && strb.ackLow) |=> !dmaReq);

  // R11
  shared_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.irqShare && irqOe) |-> !irqOut);

endmodule

bind hostBusSlave hostBusChecker uChk (
  .clk(clk), .rst(rst), .dataOe(dataOe), .dmaReq(dmaReq),
  .termCount(termCount), .fifoReady(fifoReady), .irqOe(irqOe),
  .irqOut(irqOut), .strb(strb), .cfg(cfg)
);

// File: tb/sim_hostBusSlave.sv
`timescale 1ns/1ps
module sim_hostBusSlave;

  localparam logic [10:0] BASE = 11'h2E8;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, aen = 1'b0, iorN = 1'b1, iowN = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic dmaAckN = 1'b1, termCount = 1'b0, fifoReady = 1'b0, lastByte = 1'b0, intReq = 1'b0;
  logic [7:0] dataOut;
  logic dataOe, dmaReq, irqOut, irqOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostBusSlave #(.BASE_ADDR(BASE), .PULSE_CYCLES(PULSE)) u0 (
    .clk(clk), .rst(rst), .csN(csN), .aen(aen), .addr(addr), .iorN(iorN),
    .iowN(iowN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .dmaAckN(dmaAckN), .termCount(termCount), .fifoReady(fifoReady),
    .lastByte(lastByte), .dmaReq(dmaReq), .intReq(intReq), .irqOut(irqOut),
    .irqOe(irqOe)
  );

  function automatic bit expHit(input logic [10:0] a, input logic cs, input logic en);
    return !cs && !en && (a[10:2] == BASE[10:2]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [10:0] a, input logic cs, input logic en, input logic [7:0] d);
    @(negedge clk); addr = a; csN = cs; aen = en; dataIn = d;
    @(negedge clk); iowN = 1'b0;
    idle(4); iowN = 1'b1;
    idle(4); csN = 1'b1;
  endtask

  task automatic busRead(input logic [10:0] a, input logic cs, input logic en,
                         input logic [10:0] aLate, output logic oe, output logic [7:0] d);
    @(negedge clk); addr = a; csN = cs; aen = en;
    @(negedge clk); iorN = 1'b0;
    idle(4); addr = aLate;
    idle(1); oe = dataOe; d = dataOut;
    iorN = 1'b1;
    idle(4); csN = 1'b1;
  endtask

  logic [7:0] model [4];

  initial begin
    logic oe;
    logic [7:0] d;
    void'($urandom(32'd2024));
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1", dmaReq, 0);
    check("R1", dataOe, 0);

    // config and scratch across reset
    busWrite(BASE + 0, 0, 0, 8'h00);
    busWrite(BASE + 2, 0, 0, 8'hA5);
    busRead(BASE + 2, 0, 0, BASE + 2, oe, d);
    check("R6", {oe, d}, {1'b1, 8'hA5});
    busWrite(BASE + 0, 0, 0, 8'h60);
    @(negedge clk); rst = 1'b1; idle(3); rst = 1'b0; idle(2);
    busRead(BASE + 0, 0, 0, BASE + 0, oe, d);
    check("R1", d, 8'h60);
    busRead(BASE + 2, 0, 0, BASE + 2, oe, d);
    check("R1", d, 8'h00);
    busWrite(BASE + 0, 0, 0, 8'h00);
    for (int i = 0; i < 4; i++) model[i] = 8'h00;

    // R4: address changed mid-strobe
    busWrite(BASE + 3, 0, 0, 8'h3C);
    model[3] = 8'h3C;
    busRead(BASE + 3, 0, 0, BASE + 1, oe, d);
    check("R4", {oe, d}, {1'b1, 8'h3C});

    // random accesses, mixing qualified and disqualified cycles
    for (int it = 0; it < 40; it++) begin
      int idx = 1 + int'($urandom % 3);
      logic [7:0] v = 8'($urandom);
      int kind = int'($urandom % 4);
      logic [10:0] a = BASE + 11'(idx);
      logic cs = 1'b0, en = 1'b0;
      case (kind)
        1: cs = 1'b1;
        2: en = 1'b1;
        3: a = a ^ (11'd1 << (2 + ($urandom % 9)));
        default: ;
      endcase
      busWrite(a, cs, en, v);
      if (expHit(a, cs, en)) model[idx] = v;
      busRead(a, cs, en, a, oe, d);
      check(kind == 0 ? "R5" : (kind == 3 ? "R2" : "R3"), oe, expHit(a, cs, en));
      busRead(BASE + 11'(idx), 0, 0, BASE + 11'(idx), oe, d);
      check(kind == 0 ? "R6" : "R3", {oe, d}, {1'b1, model[idx]});
    end

    // DMA: R7 enable gating
    fifoReady = 1'b1; idle(4);
    check("R7", dmaReq, 0);
    busWrite(BASE + 0, 0, 0, 8'h01); idle(4);
    check("R7", dmaReq, 1);
    // R8 single mode
    dmaAckN = 1'b0; idle(4);
    check("R8", dmaReq, 0);
    // R13 DMA read and write
    busRead(BASE + 7, 1, 1, BASE + 7, oe, d);
    check("R13", {oe, d}, {1'b1, model[1]});
    busWrite(11'h000, 1, 1, 8'h5A);
    model[1] = 8'h5A;
    dmaAckN = 1'b1; aen = 1'b0; idle(4);
    check("R8", dmaReq, 1);
    busRead(BASE + 1, 0, 0, BASE + 1, oe, d);
    check("R13", d, 8'h5A);

    // R9 demand mode
    busWrite(BASE + 0, 0, 0, 8'h03); idle(4);
    dmaAckN = 1'b0; idle(4);
    check("R9", dmaReq, 1);
    lastByte = 1'b0;
    busRead(11'h000, 1, 1, 11'h000, oe, d);
    check("R9", dmaReq, 1);
    lastByte = 1'b1;
    busRead(11'h000, 1, 1, 11'h000, oe, d);
    check("R9", dmaReq, 0);
    lastByte = 1'b0; aen = 1'b0;
    dmaAckN = 1'b1; idle(4);
    check("R9", dmaReq, 1);

    // R10 terminal count
    termCount = 1'b1; idle(4); termCount = 1'b0; idle(2);
    check("R10", dmaReq, 1);
    dmaAckN = 1'b0; idle(4);
    termCount = 1'b1; idle(1); termCount = 1'b0; idle(2);
    check("R10", dmaReq, 0);
    dmaAckN = 1'b1; idle(5);
    check("R10", dmaReq, 0);
    busWrite(BASE + 0, 0, 0, 8'h03); idle(4);
    check("R10", dmaReq, 1);

    // R12 level interrupt (also clears DMA enable)
    busWrite(BASE + 0, 0, 0, 8'h04); idle(2);
    check("R7", dmaReq, 0);
    intReq = 1'b1; idle(1);
    check("R12", {irqOe, irqOut}, 2'b11);
    intReq = 1'b0; idle(1);
    check("R12", {irqOe, irqOut}, 2'b10);

    // R11 shared pulse
    busWrite(BASE + 0, 0, 0, 8'h0C); idle(2);
    check("R11", irqOe, 0);
    intReq = 1'b1; idle(1);
    check("R11", {irqOe, irqOut}, 2'b10);
    idle(PULSE - 1);
    check("R11", {irqOe, irqOut}, 2'b10);
    idle(1);
    check("R11", irqOe, 0);
    idle(3);
    check("R11", irqOe, 0);
    intReq = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule